// File: doc/BRIEF.md
# Segment Register File with Hidden Descriptor Cache

This block holds the six segment registers of an address-translation front end. Each register has a visible selector and a hidden copy of the segment's base, limit and access-rights byte. The hidden copy is written in the same clock edge as the selector, from a descriptor payload that the surrounding logic has already fetched. Every later translation therefore reads base and limit from local flops and needs no descriptor memory traffic.

On the read side, the caller gives an access kind: fetch, stack, data or string destination. The block chooses the default register for that kind and honours an optional register override. It returns the chosen register's selector, base, limit and access byte in the same cycle.

The current privilege level is the low two bits of the code register's selector. Ordinary loads cannot change the code register; only far-transfer or interrupt-class loads can. When long mode is on, the four legacy registers read as base zero with a limit of all ones. The two auxiliary registers keep their cached base in that mode.

Top module: `seg_file`

## Requirements
- R1: After reset, every register holds selector 0, base 0, limit 0xFFFF (zero-extended) and access byte 0, and `cpl` is 0.
- R2: A load with `ld_en`=1 to index 0 (extra), 2 (stack), 3 (data), 4 (aux0) or 5 (aux1) stores selector, base, limit and access byte together. The new values are visible on the read port from the cycle after the clock edge.
- R3: A load with `ld_en`=1, `ld_far`=0 and `ld_idx`=1 (code) leaves the code register unchanged. `ld_illegal` is 1 in that same cycle and 0 in every other case.
- R4: A load with `ld_far`=1 may target any index from 0 to 5, including code (index 1).
- R5: `cpl` always equals bits [1:0] of the code register's selector.
- R6: With no override, `rd_kind` picks the register combinationally: 0 (fetch) gives code, 1 (stack) gives stack, 2 (data) gives data, 3 (string destination) gives extra. `rd_seg` reports the chosen index.
- R7: With `rd_ovr_en`=1 and `rd_kind` equal to 1 or 2, `rd_ovr_idx` values 0 to 5 select that register. The override is ignored for kinds 0 and 3, and for override values 6 and 7.
- R8: With `long_mode`=1, a chosen index 0 to 3 reads base 0 and an all-ones limit, while indices 4 and 5 read their stored values. Stored contents are untouched and reappear when `long_mode` returns to 0.
- R9: A load to index 6 or 7 changes no register and does not raise `ld_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load strobe |
| ld_far | input | 1 | Load is far-transfer or interrupt class |
| ld_idx | input | 3 | Target register index |
| ld_sel | input | SEL_W | Selector to load |
| ld_base | input | BASE_W | Cached base to load |
| ld_lim | input | LIM_W | Cached limit to load |
| ld_acc | input | ACC_W | Cached access byte to load |
| ld_illegal | output | 1 | Ordinary load aimed at code register |
| long_mode | input | 1 | Forces legacy bases to zero |
| rd_kind | input | 2 | Access kind |
| rd_ovr_en | input | 1 | Override valid |
| rd_ovr_idx | input | 3 | Override register index |
| rd_seg | output | 3 | Chosen register index |
| rd_sel | output | SEL_W | Chosen selector |
| rd_base | output | BASE_W | Chosen base |
| rd_lim | output | LIM_W | Chosen limit |
| rd_acc | output | ACC_W | Chosen access byte |
| cpl | output | 2 | Current privilege level |

## Verification
The bench builds the block with 16-bit selectors, a 32-bit base, a 32-bit limit, an 8-bit access byte and the override path enabled. With a 32-bit limit, the all-ones limit forced in long mode is clearly different from the 0xFFFF reset limit. Enabling the override path lets random reads reach the auxiliary registers and also test the override values 6 and 7, which must be rejected.

// File: rtl/seg_pkg.sv
package seg_pkg;
   localparam int NUM_SEGS  = 6;
   localparam int LM_FORCED = 4;   // indices below this are flattened in long mode

   typedef enum logic [2:0] {
      SEG_EXTRA = 3'd0,
      SEG_CODE  = 3'd1,
      SEG_STACK = 3'd2,
      SEG_DATA  = 3'd3,
      SEG_AUX0  = 3'd4,
      SEG_AUX1  = 3'd5
   } seg_id_e;

   typedef enum logic [1:0] {
      ACC_FETCH  = 2'd0,
      ACC_STACK  = 2'd1,
      ACC_DATA   = 2'd2,
      ACC_STRDST = 2'd3
   } acc_kind_e;
endpackage

// File: rtl/seg_slot.sv
module seg_slot #(
   parameter int SEL_W  = 16,
   parameter int BASE_W = 32,
   parameter int LIM_W  = 32,
   parameter int ACC_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [SEL_W-1:0]  d_sel,
   input  logic [BASE_W-1:0] d_base,
   input  logic [LIM_W-1:0]  d_lim,
   input  logic [ACC_W-1:0]  d_acc,
   output logic [SEL_W-1:0]  q_sel,
   output logic [BASE_W-1:0] q_base,
   output logic [LIM_W-1:0]  q_lim,
   output logic [ACC_W-1:0]  q_acc
);
   localparam logic [LIM_W-1:0] RST_LIM = LIM_W'(16'hFFFF);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_sel  <= '0;
         q_base <= '0;
         q_lim  <= RST_LIM;
         q_acc  <= '0;
      end else if (wr) begin
         q_sel  <= d_sel;
         q_base <= d_base;
         q_lim  <= d_lim;
         q_acc  <= d_acc;
      end
   end

   assert_slot_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (q_sel == $past(d_sel) && q_base == $past(d_base) &&
              q_lim == $past(d_lim) && q_acc == $past(d_acc)));

   assert_slot_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && $past(rst_n)) |=> $stable(q_sel) && $stable(q_base));
endmodule

// File: rtl/seg_pick.sv
module seg_pick
   import seg_pkg::*;
#(
   parameter bit OVR_ENABLE = 1'b1
) (
   input  logic [1:0] kind,
   input  logic       ovr_en,
   input  logic [2:0] ovr_idx,
   output logic [2:0] seg_id
);
   logic [2:0] def_id;
   logic       ovr_ok;

   always_comb begin
      case (acc_kind_e'(kind))
         ACC_FETCH: def_id = SEG_CODE;
         ACC_STACK: def_id = SEG_STACK;
         ACC_DATA:  def_id = SEG_DATA;
         default:   def_id = SEG_EXTRA;
      endcase
   end

   generate
      if (OVR_ENABLE) begin : g_ovr
         assign ovr_ok = ovr_en
                      && (kind == ACC_STACK || kind == ACC_DATA)
                      && (ovr_idx < 3'(NUM_SEGS));
      end else begin : g_no_ovr
         assign ovr_ok = 1'b0;
      end
   endgenerate

   assign seg_id = ovr_ok ? ovr_idx : def_id;
endmodule

// File: rtl/seg_file.sv
module seg_file
   import seg_pkg::*;
#(
   parameter int SEL_W      = 16,
   parameter int BASE_W     = 32,
   parameter int LIM_W      = 32,
   parameter int ACC_W      = 8,
   parameter bit OVR_ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic              ld_far,
   input  logic [2:0]        ld_idx,
   input  logic [SEL_W-1:0]  ld_sel,
   input  logic [BASE_W-1:0] ld_base,
   input  logic [LIM_W-1:0]  ld_lim,
   input  logic [ACC_W-1:0]  ld_acc,
   output logic              ld_illegal,
   input  logic              long_mode,
   input  logic [1:0]        rd_kind,
   input  logic              rd_ovr_en,
   input  logic [2:0]        rd_ovr_idx,
   output logic [2:0]        rd_seg,
   output logic [SEL_W-1:0]  rd_sel,
   output logic [BASE_W-1:0] rd_base,
   output logic [LIM_W-1:0]  rd_lim,
   output logic [ACC_W-1:0]  rd_acc,
   output logic [1:0]        cpl
);
   generate
      if (SEL_W < 2)   begin : g_chk_sel  $error("SEL_W must hold a privilege field"); end
      if (BASE_W < 16) begin : g_chk_base $error("BASE_W below 16 bits"); end
      if (LIM_W < 16)  begin : g_chk_lim  $error("LIM_W below 16 bits"); end
      if (ACC_W < 1)   begin : g_chk_acc  $error("ACC_W must be positive"); end
   endgenerate

   logic [SEL_W-1:0]  sel_q  [NUM_SEGS];
   logic [BASE_W-1:0] base_q [NUM_SEGS];
   logic [LIM_W-1:0]  lim_q  [NUM_SEGS];
   logic [ACC_W-1:0]  acc_q  [NUM_SEGS];
   logic [NUM_SEGS-1:0] wr_vec;

   // One cached register per segment; code accepts far-class loads only.
   generate
      for (genvar g = 0; g < NUM_SEGS; g++) begin : g_slot
         if (g == int'(SEG_CODE)) begin : g_guard
            assign wr_vec[g] = ld_en && ld_far && (ld_idx == 3'(g));
         end else begin : g_open
            assign wr_vec[g] = ld_en && (ld_idx == 3'(g));
         end
         seg_slot #(.SEL_W(SEL_W), .BASE_W(BASE_W), .LIM_W(LIM_W), .ACC_W(ACC_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .wr(wr_vec[g]),
            .d_sel(ld_sel), .d_base(ld_base), .d_lim(ld_lim), .d_acc(ld_acc),
            .q_sel(sel_q[g]), .q_base(base_q[g]), .q_lim(lim_q[g]), .q_acc(acc_q[g])
         );
      end
   endgenerate

   assign ld_illegal = ld_en && !ld_far && (ld_idx == SEG_CODE);
   assign cpl        = sel_q[SEG_CODE][1:0];

   seg_pick #(.OVR_ENABLE(OVR_ENABLE)) u_pick (
      .kind(rd_kind), .ovr_en(rd_ovr_en), .ovr_idx(rd_ovr_idx), .seg_id(rd_seg)
   );

   always_comb begin
      rd_sel  = '0;
      rd_base = '0;
      rd_lim  = '0;
      rd_acc  = '0;
      for (int i = 0; i < NUM_SEGS; i++) begin
         if (rd_seg == 3'(i)) begin
            rd_sel  = sel_q[i];
            rd_base = base_q[i];
            rd_lim  = lim_q[i];
            rd_acc  = acc_q[i];
         end
      end
      if (long_mode && (rd_seg < 3'(LM_FORCED))) begin
         rd_base = '0;
         rd_lim  = '1;
      end
   end

   assert_code_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !ld_far && ld_idx == SEG_CODE) |=> $stable(cpl) && $stable(sel_q[SEG_CODE]));

   assert_cpl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ld_en && ld_far && ld_idx == SEG_CODE) && $past(rst_n)) |=> $stable(cpl));

   assert_fetch_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_kind == ACC_FETCH) |-> (rd_seg == SEG_CODE));

   assert_strdst_extra_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_kind == ACC_STRDST) |-> (rd_seg == SEG_EXTRA));

   assert_pick_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_seg < 3'(NUM_SEGS));

   assert_long_flat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (long_mode && rd_seg < 3'(LM_FORCED)) |-> (rd_base == '0 && rd_lim == '1));

   assert_dead_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && ld_idx >= 3'(NUM_SEGS)) |-> (wr_vec == '0 && !ld_illegal));
endmodule

// File: tb/tb_seg_file.sv
module tb_seg_file;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 1'b0, ld_far = 1'b0;
   logic [2:0]  ld_idx = '0;
   logic [15:0] ld_sel = '0;
   logic [31:0] ld_base = '0, ld_lim = '0;
   logic [7:0]  ld_acc = '0;
   logic        ld_illegal;
   logic        long_mode = 1'b0;
   logic [1:0]  rd_kind = '0;
   logic        rd_ovr_en = 1'b0;
   logic [2:0]  rd_ovr_idx = '0;
   logic [2:0]  rd_seg;
   logic [15:0] rd_sel;
   logic [31:0] rd_base, rd_lim;
   logic [7:0]  rd_acc;
   logic [1:0]  cpl;

   int checks = 0;
   int errors = 0;

   logic [15:0] m_sel  [6];
   logic [31:0] m_base [6];
   logic [31:0] m_lim  [6];
   logic [7:0]  m_acc  [6];

   seg_file dut (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_far(ld_far), .ld_idx(ld_idx),
      .ld_sel(ld_sel), .ld_base(ld_base), .ld_lim(ld_lim), .ld_acc(ld_acc),
      .ld_illegal(ld_illegal), .long_mode(long_mode), .rd_kind(rd_kind),
      .rd_ovr_en(rd_ovr_en), .rd_ovr_idx(rd_ovr_idx), .rd_seg(rd_seg),
      .rd_sel(rd_sel), .rd_base(rd_base), .rd_lim(rd_lim), .rd_acc(rd_acc), .cpl(cpl)
   );

   always #2 clk = ~clk;   // 250 MHz

   function automatic int exp_pick(input logic [1:0] k, input logic oe, input logic [2:0] oi);
      int d;
      case (k)
         2'd0: d = 1;
         2'd1: d = 2;
         2'd2: d = 3;
         default: d = 0;
      endcase
      if (oe && (k == 2'd1 || k == 2'd2) && oi < 3'd6) d = int'(oi);
      return d;
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic read_chk(input string req, input logic [1:0] k, input logic oe,
                           input logic [2:0] oi, input logic lm);
      int s;
      logic [31:0] eb, el;
      rd_kind = k; rd_ovr_en = oe; rd_ovr_idx = oi; long_mode = lm;
      #1;
      s  = exp_pick(k, oe, oi);
      eb = (lm && s < 4) ? 32'h0 : m_base[s];
      el = (lm && s < 4) ? 32'hFFFF_FFFF : m_lim[s];
      chk(req, "seg",  32'(rd_seg), 32'(s));
      chk(req, "sel",  32'(rd_sel), 32'(m_sel[s]));
      chk(req, "base", rd_base, eb);
      chk(req, "lim",  rd_lim, el);
      chk(req, "acc",  32'(rd_acc), 32'(m_acc[s]));
   endtask

   // Reach any register index through the read port.
   task automatic read_idx(input string req, input int i, input logic lm);
      case (i)
         0: read_chk(req, 2'd3, 1'b0, 3'd0, lm);
         1: read_chk(req, 2'd0, 1'b0, 3'd0, lm);
         default: read_chk(req, 2'd2, 1'b1, 3'(i), lm);
      endcase
   endtask

   task automatic load(input string req, input logic [2:0] idx, input logic far,
                       input logic [15:0] s, input logic [31:0] b,
                       input logic [31:0] l, input logic [7:0] a);
      @(negedge clk);
      ld_en = 1'b1; ld_far = far; ld_idx = idx;
      ld_sel = s; ld_base = b; ld_lim = l; ld_acc = a;
      #1;
      chk((idx == 3'd1 && !far) ? "R3" : (idx >= 3'd6 ? "R9" : req), "ld_illegal",
          32'(ld_illegal), 32'(idx == 3'd1 && !far));
      @(posedge clk);
      #1;
      ld_en = 1'b0;
      if (idx < 3'd6 && (idx != 3'd1 || far)) begin
         m_sel[idx] = s; m_base[idx] = b; m_lim[idx] = l; m_acc[idx] = a;
      end
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      for (int i = 0; i < 6; i++) begin
         m_sel[i] = '0; m_base[i] = '0; m_lim[i] = 32'h0000_FFFF; m_acc[i] = '0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < 6; i++) read_idx("R1", i, 1'b0);
      chk("R1", "cpl", 32'(cpl), 32'd0);

      // R2 ordinary loads to every non-code register
      for (int i = 0; i < 6; i++)
         if (i != 1) load("R2", 3'(i), 1'b0, 16'(16'h1000 + i), 32'h2000_0000 + 32'(i),
                          32'h0003_0000 + 32'(i), 8'(8'h90 + i));
      for (int i = 0; i < 6; i++) read_idx("R2", i, 1'b0);

      // R3 ordinary load to code ignored
      load("R3", 3'd1, 1'b0, 16'hBEEF, 32'h1234_5678, 32'h1, 8'h55);
      read_idx("R3", 1, 1'b0);
      chk("R3", "cpl", 32'(cpl), 32'd0);

      // R4 / R5 far load to code
      load("R4", 3'd1, 1'b1, 16'h0083, 32'h0040_0000, 32'h000F_FFFF, 8'h9B);
      read_idx("R4", 1, 1'b0);
      chk("R5", "cpl", 32'(cpl), 32'd3);
      load("R4", 3'd1, 1'b1, 16'h0102, 32'h0050_0000, 32'h0000_FFFF, 8'h9A);
      chk("R5", "cpl", 32'(cpl), 32'd2);

      // R6 defaults, R7 override rules
      for (int k = 0; k < 4; k++) read_chk("R6", 2'(k), 1'b0, 3'd0, 1'b0);
      read_chk("R7", 2'd2, 1'b1, 3'd5, 1'b0);
      read_chk("R7", 2'd1, 1'b1, 3'd4, 1'b0);
      read_chk("R7", 2'd0, 1'b1, 3'd4, 1'b0);
      read_chk("R7", 2'd3, 1'b1, 3'd2, 1'b0);
      read_chk("R7", 2'd2, 1'b1, 3'd7, 1'b0);
      read_chk("R7", 2'd1, 1'b1, 3'd6, 1'b0);

      // R8 long mode flattening, then restore
      for (int i = 0; i < 6; i++) read_idx("R8", i, 1'b1);
      for (int i = 0; i < 6; i++) read_idx("R8", i, 1'b0);

      // R9 dead indices
      load("R9", 3'd6, 1'b0, 16'hFFFF, 32'hFFFF_FFFF, 32'h0, 8'hFF);
      load("R9", 3'd7, 1'b1, 16'hFFFF, 32'hFFFF_FFFF, 32'h0, 8'hFF);
      for (int i = 0; i < 6; i++) read_idx("R9", i, 1'b0);

      // Random mix
      for (int n = 0; n < 400; n++) begin
         load("R2", 3'($urandom % 8), ($urandom % 4) == 0, 16'($urandom),
              $urandom, $urandom, 8'($urandom));
         read_chk("R7", 2'($urandom % 4), 1'($urandom % 2), 3'($urandom % 8), 1'($urandom % 2));
         chk("R5", "cpl", 32'(cpl), 32'(m_sel[1][1:0]));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule